// File: doc/BRIEF.md
# Byte-wide NOR flash command and status controller

This block models the control logic of a byte-wide NOR flash memory. A host drives chip enable, output enable and write enable, an address and a data byte, much as it would drive a static RAM. Bus writes do not store data in the array. They act as commands to a sequencer. Only a complete unlock sequence starts an operation, and the block then runs that operation under its own timing.

Two operations exist. The first programs one byte, and a program can only clear bits. The second erases one of 32 equal sectors. An erase first programs every byte of the sector to zero, then waits a fixed erase time, then sets every byte of the sector to 0xFF. The timed phases are configurable cycle counts, not real pulse durations. While an operation runs, the host can poll it in three ways: a data-polling bit on bit 7 of the read data, a bit 6 that flips on every read cycle, and a ready output. An erase can be placed on hold so that other sectors can be read or programmed, and then resumed. A low-supply input blocks new program and erase commands. The active-low reset aborts any operation.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset, rdy is 1, and dq_out is 0x00 whenever the bus is not in a read cycle. A read cycle means ce_n=0, oe_n=0 and we_n=1.
- R2: A bus write is taken on the clock where ce_n=0 and we_n=0 and we_n was 1 on the previous clock. The address and the data are captured on that same clock. A program starts with three writes: 0xAA at the unlock address A1, 0x55 at unlock address A2, then 0xA0 at A1. A1 and A2 are the low ADDR_W bits of 0xAAA and 0x555 (0x2AA and 0x155 at the default width). The fourth write gives the target address and data. rdy is then 0 for exactly PROG_CYC cycles, and afterwards the byte reads back.
- R3: A programmed byte becomes the old value AND the written data. A bit that is already 0 stays 0.
- R4: A sector erase takes six writes: 0xAA@A1, 0x55@A2, 0x80@A1, 0xAA@A1, 0x55@A2, then 0x30 at any address inside the target sector. The sector index is the top 5 address bits. rdy is then 0 for 2*(sector bytes)+ERASE_CYC cycles. Afterwards every byte of that sector reads 0xFF, and the other sectors are unchanged.
- R5: While an operation is busy, every read returns a status byte. In it, bit 7 is the inverse of bit 7 of the data being programmed during a program, and 0 during an erase. Bits 5..0 are 0.
- R6: While busy, status bit 6 inverts between consecutive read cycles. While idle or erase-suspended it does not change.
- R7: rdy is 0 exactly while a program or erase is running. rdy is 1 while idle and while an erase is suspended.
- R8: A write that does not match the next step of a sequence returns the sequencer to read mode, and no operation starts.
- R9: Writing 0xB0 during an erase suspends it on the following cycle. While suspended, the erasing sector reads as status with bit 7 at 0. Other sectors read as array data and can be programmed. Writing 0x30 resumes the erase, which then completes normally.
- R10: During a suspend, a program aimed at the sector being erased is ignored, and rdy stays 1.
- R11: While lv_lock is 1, program and erase sequences start nothing.
- R12: Driving rst_n low aborts a running operation. After reset release the block is in read mode with rdy at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserts asynchronously, aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data or status byte |
| lv_lock | input | 1 | Low-supply indication, blocks program and erase |
| rdy | output | 1 | 1 when ready, 0 while an operation runs |

## Verification
The bench measures the exact busy windows of a program and of an erase. A controller whose counters are off by one cycle, or that skips the zero-fill phase of an erase, reports the wrong count. It reprograms a byte with data that has a 1 where the byte already holds a 0, which catches any controller that overwrites bits instead of clearing them. Around a suspend, it checks that the controller stops toggling bit 6, serves other sectors, refuses a program to the sector being erased, and finishes the erase after the resume. A wrong design would show a changing bit 6 or a dropped rdy during the suspend. It also checks that a broken unlock sequence, the low-supply input and a mid-erase reset each leave rdy high and the array readable, which exposes a sequencer that does not fall back to read mode.

// File: rtl/nor_ctl_pkg.sv
package nor_ctl_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_PROG, OP_ERPRE, OP_ERWAIT, OP_ERSET, OP_SUSP, OP_SPROG
  } op_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PA, SQ_E1, SQ_E2, SQ_E3
  } seq_t;

  localparam logic [7:0] CMD_UNLK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLK2 = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ESET  = 8'h80;
  localparam logic [7:0] CMD_GO30  = 8'h30;
  localparam logic [7:0] CMD_HOLD  = 8'hB0;
endpackage

// File: rtl/nor_array.sv
module nor_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [7:0]        wd,
  input  logic [ADDR_W-1:0] ra0,
  output logic [7:0]        rd0,
  input  logic [ADDR_W-1:0] ra1,
  output logic [7:0]        rd1
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_ctl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              erase_act,
  input  logic              lv_lock,
  output logic              go_prog,
  output logic              go_erase,
  output logic              go_susp,
  output logic              go_resume
);
  localparam logic [ADDR_W-1:0] UL1 = ADDR_W'(12'hAAA);
  localparam logic [ADDR_W-1:0] UL2 = ADDR_W'(12'h555);

  seq_t sq, sq_n;

  always_comb begin
    sq_n      = sq;
    go_prog   = 1'b0;
    go_erase  = 1'b0;
    go_susp   = 1'b0;
    go_resume = 1'b0;
    if (busy) begin
      sq_n    = SQ_IDLE;
      go_susp = wr_stb && erase_act && (wr_data == CMD_HOLD);
    end else if (wr_stb) begin
      sq_n = SQ_IDLE;
      case (sq)
        SQ_IDLE: begin
          if (wr_data == CMD_UNLK1 && wr_addr == UL1) sq_n = SQ_U1;
          else if (wr_data == CMD_GO30) go_resume = 1'b1;
        end
        SQ_U1: if (wr_data == CMD_UNLK2 && wr_addr == UL2) sq_n = SQ_U2;
        SQ_U2: begin
          if (wr_addr == UL1 && wr_data == CMD_PROG) sq_n = SQ_PA;
          else if (wr_addr == UL1 && wr_data == CMD_ESET) sq_n = SQ_E1;
        end
        SQ_PA: go_prog = !lv_lock;
        SQ_E1: if (wr_data == CMD_UNLK1 && wr_addr == UL1) sq_n = SQ_E2;
        SQ_E2: if (wr_data == CMD_UNLK2 && wr_addr == UL2) sq_n = SQ_E3;
        SQ_E3: go_erase = !lv_lock && (wr_data == CMD_GO30);
        default: sq_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sq <= SQ_IDLE;
    else         sq <= sq_n;
  end

  // R8: an operation can only start from the last step of a sequence
  assert_start_from_seq_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (go_prog || go_erase) |-> (sq == SQ_PA || sq == SQ_E3));
endmodule

// File: rtl/nor_op_engine.sv
module nor_op_engine
  import nor_ctl_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_SECT  = 32,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              go_prog,
  input  logic              go_erase,
  input  logic              go_susp,
  input  logic              go_resume,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        mem_rd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_a,
  output logic [7:0]        mem_wd,
  output logic              busy,
  output logic              erase_act,
  output logic              susp,
  output logic              stat7,
  output logic [$clog2(NUM_SECT)-1:0] esect
);
  localparam int SEC_W = $clog2(NUM_SECT);
  localparam int IDX_W = ADDR_W - SEC_W;
  localparam int SB    = 1 << IDX_W;
  localparam int PCW   = $clog2(PROG_CYC + 1);
  localparam int ECW   = $clog2(ERASE_CYC + 1);

  op_t              st, st_n, sph, sph_n;
  logic [PCW-1:0]   p_cnt, p_cnt_n;
  logic [ECW-1:0]   e_cnt, e_cnt_n;
  logic [IDX_W-1:0] e_idx, e_idx_n;
  logic [ADDR_W-1:0] pa, pa_n;
  logic [7:0]       pd, pd_n;
  logic [SEC_W-1:0] esec, esec_n;

  assign erase_act = (st == OP_ERPRE) || (st == OP_ERWAIT) || (st == OP_ERSET);
  assign busy      = erase_act || (st == OP_PROG) || (st == OP_SPROG);
  assign susp      = (st == OP_SUSP);
  assign stat7     = ((st == OP_PROG) || (st == OP_SPROG)) ? ~pd[7] : 1'b0;
  assign esect     = esec;
  assign mem_a     = ((st == OP_PROG) || (st == OP_SPROG)) ? pa : {esec, e_idx};

  always_comb begin
    st_n = st; sph_n = sph; p_cnt_n = p_cnt; e_cnt_n = e_cnt; e_idx_n = e_idx;
    pa_n = pa; pd_n = pd; esec_n = esec;
    mem_we = 1'b0;
    mem_wd = 8'h00;
    if (erase_act && go_susp) begin
      st_n  = OP_SUSP;
      sph_n = st;
    end else begin
      case (st)
        OP_IDLE: begin
          if (go_prog) begin
            st_n = OP_PROG; pa_n = wr_addr; pd_n = wr_data; p_cnt_n = '0;
          end else if (go_erase) begin
            st_n = OP_ERPRE; esec_n = wr_addr[ADDR_W-1 -: SEC_W]; e_idx_n = '0;
          end
        end
        OP_PROG, OP_SPROG: begin
          if (p_cnt == PCW'(PROG_CYC - 1)) begin
            mem_we = 1'b1;
            mem_wd = mem_rd & pd;
            st_n   = (st == OP_PROG) ? OP_IDLE : OP_SUSP;
          end else p_cnt_n = p_cnt + 1'b1;
        end
        OP_ERPRE: begin
          mem_we = (mem_rd != 8'h00);
          if (e_idx == IDX_W'(SB - 1)) begin
            st_n = OP_ERWAIT; e_cnt_n = '0;
          end else e_idx_n = e_idx + 1'b1;
        end
        OP_ERWAIT: begin
          if (e_cnt == ECW'(ERASE_CYC - 1)) begin
            st_n = OP_ERSET; e_idx_n = '0;
          end else e_cnt_n = e_cnt + 1'b1;
        end
        OP_ERSET: begin
          mem_we = 1'b1;
          mem_wd = 8'hFF;
          if (e_idx == IDX_W'(SB - 1)) st_n = OP_IDLE;
          else e_idx_n = e_idx + 1'b1;
        end
        OP_SUSP: begin
          if (go_resume) st_n = sph;
          else if (go_prog && wr_addr[ADDR_W-1 -: SEC_W] != esec) begin
            st_n = OP_SPROG; pa_n = wr_addr; pd_n = wr_data; p_cnt_n = '0;
          end
        end
        default: st_n = OP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= OP_IDLE; sph <= OP_ERPRE; p_cnt <= '0; e_cnt <= '0; e_idx <= '0;
      pa <= '0; pd <= '0; esec <= '0;
    end else begin
      st <= st_n; sph <= sph_n; p_cnt <= p_cnt_n; e_cnt <= e_cnt_n;
      e_idx <= e_idx_n; pa <= pa_n; pd <= pd_n; esec <= esec_n;
    end
  end

  // R10: a program during suspend never targets the erasing sector
  assert_sprog_other_sector_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (st == OP_SPROG) |-> (pa[ADDR_W-1 -: SEC_W] != esec));

  // R2: program timer stays inside its window
  assert_prog_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    p_cnt < PCW'(PROG_CYC));

  // R9: suspend is only entered from a running erase
  assert_susp_from_erase_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (st == OP_SUSP && $past(st) != OP_SUSP && $past(st) != OP_SPROG)
      |-> ($past(st) == OP_ERPRE || $past(st) == OP_ERWAIT || $past(st) == OP_ERSET));
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_ctl_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_SECT  = 32,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  input  logic              lv_lock,
  output logic              rdy
);
  localparam int SEC_W = $clog2(NUM_SECT);

  logic [1:0] rst_sync;
  logic rst_ni;
  logic we_prev, rd_prev, tog_q, tog_n;
  logic wr_stb, rd_act, rd_end;
  logic go_prog, go_erase, go_susp, go_resume;
  logic busy, erase_act, susp, stat7;
  logic [SEC_W-1:0]  esect;
  logic mem_we;
  logic [ADDR_W-1:0] mem_a;
  logic [7:0] mem_wd, mem_rd, bus_rd, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign wr_stb = !ce_n && !we_n && we_prev;
  assign rd_act = !ce_n && !oe_n && we_n;
  assign rd_end = rd_prev && !rd_act;
  assign tog_n  = (rd_end && busy) ? ~tog_q : tog_q;
  assign rdy    = !busy;
  assign status = {stat7, tog_q, 6'b0};

  always_comb begin
    if (!rd_act)                                            dq_out = 8'h00;
    else if (busy)                                          dq_out = status;
    else if (susp && addr[ADDR_W-1 -: SEC_W] == esect)      dq_out = status;
    else                                                    dq_out = bus_rd;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      we_prev <= 1'b1; rd_prev <= 1'b0; tog_q <= 1'b0;
    end else begin
      we_prev <= we_n; rd_prev <= rd_act; tog_q <= tog_n;
    end
  end

  nor_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_ni(rst_ni), .wr_stb(wr_stb), .wr_addr(addr), .wr_data(dq_in),
    .busy(busy), .erase_act(erase_act), .lv_lock(lv_lock),
    .go_prog(go_prog), .go_erase(go_erase), .go_susp(go_susp), .go_resume(go_resume)
  );

  nor_op_engine #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .PROG_CYC(PROG_CYC),
                  .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst_ni(rst_ni), .go_prog(go_prog), .go_erase(go_erase),
    .go_susp(go_susp), .go_resume(go_resume), .wr_addr(addr), .wr_data(dq_in),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_a(mem_a), .mem_wd(mem_wd),
    .busy(busy), .erase_act(erase_act), .susp(susp), .stat7(stat7), .esect(esect)
  );

  nor_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .wa(mem_a), .wd(mem_wd),
    .ra0(addr), .rd0(bus_rd), .ra1(mem_a), .rd1(mem_rd)
  );

  // R11: with low supply, an idle controller stays idle
  assert_lv_block_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (lv_lock && !busy && !susp) |=> !busy);

  // R6: toggle bit frozen unless an operation is running
  assert_tog_steady_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |=> $stable(tog_q));
endmodule

// File: tb/nor_cmd_ctrl_test.sv
module nor_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int PC = 8;
  localparam int EC = 40;
  localparam int SB = 32;
  localparam logic [AW-1:0] A1 = 10'h2AA;
  localparam logic [AW-1:0] A2 = 10'h155;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, lv_lock;
  logic [AW-1:0] addr;
  logic [7:0] dq_in, dq_out;
  logic rdy;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_ctrl #(.ADDR_W(AW), .NUM_SECT(32), .PROG_CYC(PC), .ERASE_CYC(EC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .lv_lock(lv_lock), .rdy(rdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1; #1;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); #1; d = dq_out; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!rdy && n < 1000) begin n++; @(negedge clk); #1; end
  endtask

  task automatic prog_seq(input logic [AW-1:0] a, input logic [7:0] d);
    bus_wr(A1, 8'hAA); bus_wr(A2, 8'h55); bus_wr(A1, 8'hA0); bus_wr(a, d);
  endtask

  task automatic erase_seq(input int sec);
    bus_wr(A1, 8'hAA); bus_wr(A2, 8'h55); bus_wr(A1, 8'h80);
    bus_wr(A1, 8'hAA); bus_wr(A2, 8'h55); bus_wr(AW'(sec * SB + 5), 8'h30);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lv_lock = 1'b0;
    addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    chk("R1 rdy after reset", rdy, 1);
    chk("R1 dq_out outside read", dq_out, 8'h00);
  endtask

  task automatic t_erase_timing();
    int n; logic [7:0] d;
    erase_seq(1);
    busy_len(n);
    chk("R4 erase busy cycles", n, 2*SB + EC);
    chk("R7 rdy after erase", rdy, 1);
    bus_rd(AW'(1*SB), d);      chk("R4 first byte FF", d, 8'hFF);
    bus_rd(AW'(1*SB + 31), d); chk("R4 last byte FF", d, 8'hFF);
  endtask

  task automatic t_program();
    int n; logic [7:0] d;
    prog_seq(AW'(SB + 3), 8'h5A);
    chk("R7 rdy low during program", rdy, 0);
    bus_rd(AW'(7), d);
    chk("R5 program status bit7", d[7], 1);
    chk("R5 status low bits", d[5:0], 0);
    busy_len(n);
    bus_rd(AW'(SB + 3), d); chk("R2 programmed byte", d, 8'h5A);
    prog_seq(AW'(SB + 3), 8'hF0);
    busy_len(n);
    chk("R2 program busy cycles", n, PC);
    bus_rd(AW'(SB + 3), d); chk("R3 bits only cleared", d, 8'h50);
  endtask

  task automatic t_break();
    logic [7:0] d, e;
    bus_wr(A1, 8'hAA); bus_wr(10'h100, 8'h55); bus_wr(A1, 8'hA0); bus_wr(AW'(SB + 4), 8'h00);
    chk("R8 broken sequence no op", rdy, 1);
    bus_rd(AW'(SB + 4), d); chk("R8 byte untouched", d, 8'hFF);
    bus_rd(AW'(SB + 4), e); chk("R6 idle read steady", e, d);
  endtask

  task automatic t_lowv();
    logic [7:0] d;
    lv_lock = 1'b1;
    prog_seq(AW'(SB + 5), 8'h00);
    chk("R11 program blocked", rdy, 1);
    erase_seq(1);
    chk("R11 erase blocked", rdy, 1);
    lv_lock = 1'b0;
    bus_rd(AW'(SB + 3), d); chk("R11 data kept", d, 8'h50);
  endtask

  task automatic t_suspend();
    int n; logic [7:0] d, e;
    bool_ok: begin end
    erase_seq(0);
    bus_wr(A1, 8'hB0);
    chk("R9 rdy high when suspended", rdy, 1);
    bus_rd(AW'(2), d); bus_rd(AW'(2), e);
    chk("R9 erasing sector status bit7", d[7], 0);
    chk("R6 toggle frozen in suspend", e, d);
    bus_rd(AW'(SB + 3), d); chk("R9 other sector readable", d, 8'h50);
    prog_seq(AW'(SB + 6), 8'h33);
    busy_len(n); chk("R9 program in suspend cycles", n, PC);
    bus_rd(AW'(SB + 6), d); chk("R9 program in suspend data", d, 8'h33);
    prog_seq(AW'(1), 8'h12);
    n = 0;
    for (int i = 0; i < PC + 2; i++) begin
      if (!rdy) n++;
      @(negedge clk); #1;
    end
    chk("R10 program to erasing sector ignored", n, 0);
    bus_wr(A1, 8'h30);
    chk("R9 resume busy", rdy, 0);
    busy_len(n);
    bus_rd(AW'(1), d);  chk("R9 erase completes", d, 8'hFF);
    bus_rd(AW'(31), d); chk("R4 sector 0 last byte", d, 8'hFF);
    bus_rd(AW'(SB + 6), d); chk("R4 other sector unchanged", d, 8'h33);
  endtask

  task automatic t_abort();
    int n; logic [7:0] d, e;
    erase_seq(2);
    bus_rd(AW'(9), d); bus_rd(AW'(9), e);
    chk("R5 erase status bit7", d[7], 0);
    chk("R6 toggle while busy", d[6] ^ e[6], 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    chk("R12 rdy after abort", rdy, 1);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (!rdy) n++;
      @(negedge clk); #1;
    end
    chk("R12 operation stays aborted", n, 0);
    bus_rd(AW'(SB + 3), d); chk("R12 read mode after abort", d, 8'h50);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_erase_timing();
    t_program();
    t_break();
    t_lowv();
    t_suspend();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule